// File: doc/BRIEF.md
# Per-Set Age-Based Replacement Selector

This block holds the replacement state for a single set of an N-way cache and picks the way to evict. Each way has a small saturating age counter that estimates how far off its next use is. A hit on a way sets its age to zero, which marks it as recently useful. A fill loads the way's age with a configurable insertion value. That value normally sits close to the maximum, so a newly filled block that is never touched again leaves the set early.

The cache controller raises a one-cycle victim request when it needs a way to replace. Any invalid way is taken first, in one cycle. If every way is valid, the lowest-numbered way whose age is at the maximum is chosen. If no way is at the maximum, all counters advance by one per cycle until one of them reaches it. `done_o` pulses for one cycle with the chosen way on `victim_o`. With a counter width of 1 and an insertion value of 0, the same logic behaves as plain not-recently-used replacement.

Top module: `age_victim_sel`

## Requirements
- R1: After reset, `done_o` is low and every way's age is at the maximum, so the first request with all ways valid returns way 0 one cycle later.
- R2: A hit on way w sets the age of w to 0 on the next clock edge and leaves the other ways unchanged.
- R3: A fill of way w loads the age of w with `INS_AGE`. When a hit and a fill name the same way in the same cycle, the fill wins.
- R4: If any bit of `valid_i` is 0 (0 = invalid), a request returns the lowest-numbered invalid way with `done_o` one cycle after the request, and no age changes.
- R5: If all ways are valid and at least one age equals the maximum (2^AGE_W-1), the request returns the lowest-numbered way at the maximum, one cycle after the request.
- R6: If all ways are valid and none is at the maximum, every age increases by one on each cycle until one reaches the maximum. `done_o` rises 1+(MAX-highest age) cycles after the request with the lowest-numbered way at the maximum, and the increased ages are kept.
- R7: `done_o` is a single-cycle pulse, raised once per request, and `victim_o` is below `NUM_WAYS` whenever `done_o` is high.
- R8: With AGE_W=1 and INS_AGE=0, a touched way's bit clears. A request evicts the lowest way whose bit is 1, and if all bits are 0 it sets them all to 1 and evicts the lowest way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 1 | Hit strobe |
| hit_way_i | input | IDX_W | Way that hit |
| fill_i | input | 1 | Fill strobe |
| fill_way_i | input | IDX_W | Way being filled |
| valid_i | input | NUM_WAYS | Per-way valid bit from the tag array |
| vreq_i | input | 1 | Victim request, one-cycle pulse |
| done_o | output | 1 | Victim ready pulse |
| victim_o | output | IDX_W | Selected way |

## Verification
The assertions assume that `vreq_i` is a single-cycle pulse raised only while no search is running and not in the cycle `done_o` is high. They also assume that `hit_i`, `fill_i` and `valid_i` stay quiet or stable from the request until `done_o`. The bench follows these rules: it issues each hit, fill or request alone, and it waits out a fixed window longer than the worst-case search before the next operation. Two instances, one with the default 3-bit counters and one in 1-bit mode, receive the same stimulus. Their results are compared with separate arithmetic age models.

// File: rtl/age_repl_pkg.sv
package age_repl_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_AGE  = 1'b1
  } sel_state_e;
endpackage

// File: rtl/age_way_cnt.sv
module age_way_cnt #(
  parameter int unsigned AGE_W   = 3,
  parameter int unsigned INS_AGE = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             step_i,
  output logic [AGE_W-1:0] age_o,
  output logic             at_max_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};
  localparam logic [AGE_W-1:0] AGE_INS = AGE_W'(INS_AGE);

  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= AGE_MAX;
    end else if (load_i) begin
      age_q <= AGE_INS;
    end else if (clr_i) begin
      age_q <= '0;
    end else if (step_i && (age_q != AGE_MAX)) begin
      age_q <= age_q + 1'b1;
    end
  end

  assign age_o    = age_q;
  assign at_max_o = (age_q == AGE_MAX);
endmodule

// File: rtl/low_pick.sv
module low_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/victim_fsm.sv
module victim_fsm
  import age_repl_pkg::*;
#(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vreq_i,
  input  logic             inv_any_i,
  input  logic [IDX_W-1:0] inv_idx_i,
  input  logic             max_any_i,
  input  logic [IDX_W-1:0] max_idx_i,
  output logic             step_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] victim_o
);
  sel_state_e       state_q, state_d;
  logic             done_d, done_q;
  logic [IDX_W-1:0] victim_d, victim_q;

  always_comb begin
    state_d  = state_q;
    done_d   = 1'b0;
    victim_d = victim_q;
    step_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (vreq_i) begin
          if (inv_any_i) begin
            done_d   = 1'b1;
            victim_d = inv_idx_i;
          end else if (max_any_i) begin
            done_d   = 1'b1;
            victim_d = max_idx_i;
          end else begin
            step_o  = 1'b1;
            state_d = ST_AGE;
          end
        end
      end
      ST_AGE: begin
        if (max_any_i) begin
          done_d   = 1'b1;
          victim_d = max_idx_i;
          state_d  = ST_IDLE;
        end else begin
          step_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      done_q   <= 1'b0;
      victim_q <= '0;
    end else begin
      state_q  <= state_d;
      done_q   <= done_d;
      victim_q <= victim_d;
    end
  end

  assign busy_o   = (state_q == ST_AGE);
  assign done_o   = done_q;
  assign victim_o = victim_q;
endmodule

// File: rtl/age_victim_sel.sv
module age_victim_sel #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned AGE_W    = 3,
  parameter int unsigned INS_AGE  = 6,
  localparam int unsigned IDX_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hit_i,
  input  logic [IDX_W-1:0]    hit_way_i,
  input  logic                fill_i,
  input  logic [IDX_W-1:0]    fill_way_i,
  input  logic [NUM_WAYS-1:0] valid_i,
  input  logic                vreq_i,
  output logic                done_o,
  output logic [IDX_W-1:0]    victim_o
);
  logic [NUM_WAYS*AGE_W-1:0] ages_flat;
  logic [NUM_WAYS-1:0]       at_max;
  logic                      step;
  logic                      busy;
  logic                      inv_any, max_any;
  logic [IDX_W-1:0]          inv_idx, max_idx;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    age_way_cnt #(
      .AGE_W  (AGE_W),
      .INS_AGE(INS_AGE)
    ) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (hit_i && (hit_way_i == IDX_W'(w))),
      .load_i  (fill_i && (fill_way_i == IDX_W'(w))),
      .step_i  (step),
      .age_o   (ages_flat[w*AGE_W +: AGE_W]),
      .at_max_o(at_max[w])
    );
  end

  low_pick #(.N(NUM_WAYS), .IDX_W(IDX_W)) u_inv_pick (
    .req_i(~valid_i),
    .any_o(inv_any),
    .idx_o(inv_idx)
  );

  low_pick #(.N(NUM_WAYS), .IDX_W(IDX_W)) u_max_pick (
    .req_i(at_max),
    .any_o(max_any),
    .idx_o(max_idx)
  );

  victim_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vreq_i   (vreq_i),
    .inv_any_i(inv_any),
    .inv_idx_i(inv_idx),
    .max_any_i(max_any),
    .max_idx_i(max_idx),
    .step_o   (step),
    .busy_o   (busy),
    .done_o   (done_o),
    .victim_o (victim_o)
  );
endmodule

// File: rtl/age_victim_sel_chk.sv
module age_victim_sel_chk #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned AGE_W    = 3,
  parameter int unsigned INS_AGE  = 6,
  parameter int unsigned IDX_W    = 2
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      hit_i,
  input logic [IDX_W-1:0]          hit_way_i,
  input logic                      fill_i,
  input logic [IDX_W-1:0]          fill_way_i,
  input logic [NUM_WAYS-1:0]       valid_i,
  input logic                      vreq_i,
  input logic                      done_o,
  input logic [IDX_W-1:0]          victim_o,
  input logic [NUM_WAYS*AGE_W-1:0] ages_i,
  input logic                      busy_i
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  // R2
  hit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !(fill_i && fill_way_i == hit_way_i) && !vreq_i && !busy_i)
    |=> ages_i[int'($past(hit_way_i))*AGE_W +: AGE_W] == '0);

  // R3
  fill_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !vreq_i && !busy_i)
    |=> ages_i[int'($past(fill_way_i))*AGE_W +: AGE_W] == AGE_W'(INS_AGE));

  // R4
  invalid_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !(&valid_i)) |-> !valid_i[victim_o]);

  // R5
  victim_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (&valid_i)) |-> ages_i[int'(victim_o)*AGE_W +: AGE_W] == AGE_MAX);

  // R6
  aging_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(vreq_i));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  victim_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> int'(victim_o) < NUM_WAYS);
endmodule

bind age_victim_sel age_victim_sel_chk #(
  .NUM_WAYS(NUM_WAYS),
  .AGE_W   (AGE_W),
  .INS_AGE (INS_AGE),
  .IDX_W   (IDX_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hit_i     (hit_i),
  .hit_way_i (hit_way_i),
  .fill_i    (fill_i),
  .fill_way_i(fill_way_i),
  .valid_i   (valid_i),
  .vreq_i    (vreq_i),
  .done_o    (done_o),
  .victim_o  (victim_o),
  .ages_i    (ages_flat),
  .busy_i    (busy)
);

// File: tb/age_victim_sel_bench.sv
module age_victim_sel_bench;
  localparam int NW = 4;
  localparam int MAX_A = 7;
  localparam int INS_A = 6;
  localparam int MAX_B = 1;
  localparam int INS_B = 0;
  localparam int WIN = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          hit_i = 1'b0, fill_i = 1'b0, vreq_i = 1'b0;
  logic [1:0]    hit_way_i = '0, fill_way_i = '0;
  logic [NW-1:0] valid_i = '1;
  logic          done_a, done_b;
  logic [1:0]    vict_a, vict_b;

  int checks = 0, failures = 0;
  int age_a[NW];
  int age_b[NW];
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  age_victim_sel #(.NUM_WAYS(NW), .AGE_W(3), .INS_AGE(INS_A)) u_age_victim_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit_i), .hit_way_i(hit_way_i),
    .fill_i(fill_i), .fill_way_i(fill_way_i), .valid_i(valid_i),
    .vreq_i(vreq_i), .done_o(done_a), .victim_o(vict_a)
  );

  age_victim_sel #(.NUM_WAYS(NW), .AGE_W(1), .INS_AGE(INS_B)) u_age_victim_sel_nru (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit_i), .hit_way_i(hit_way_i),
    .fill_i(fill_i), .fill_way_i(fill_way_i), .valid_i(valid_i),
    .vreq_i(vreq_i), .done_o(done_b), .victim_o(vict_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic touch(input bit h, input int hw, input bit f, input int fw);
    @(negedge clk_i);
    hit_i = h; hit_way_i = 2'(hw); fill_i = f; fill_way_i = 2'(fw);
    @(negedge clk_i);
    hit_i = 0; fill_i = 0;
    if (h) begin age_a[hw] = 0; age_b[hw] = 0; end
    if (f) begin age_a[fw] = INS_A; age_b[fw] = INS_B; end
  endtask

  // model: expected victim and latency; updates ages
  function automatic void predict(inout int ag[NW], input int mx,
                                  output int v, output int lat);
    int hi = 0;
    v = -1;
    for (int i = 0; i < NW; i++) if (!valid_i[i] && v < 0) v = i;
    if (v >= 0) begin lat = 1; return; end
    for (int i = 0; i < NW; i++) if (ag[i] > hi) hi = ag[i];
    for (int i = 0; i < NW; i++) ag[i] = ag[i] + (mx - hi);
    for (int i = 0; i < NW; i++) if (ag[i] == mx && v < 0) v = i;
    lat = 1 + (mx - hi);
  endfunction

  task automatic request(input string tag_a, input string tag_b);
    int va, la, vb, lb;
    int na = 0, nb = 0, ga = -1, gb = -1, ca = 0, cb = 0;
    predict(age_a, MAX_A, va, la);
    predict(age_b, MAX_B, vb, lb);
    @(negedge clk_i);
    vreq_i = 1;
    for (int n = 1; n <= WIN; n++) begin
      @(negedge clk_i);
      vreq_i = 0;
      if (done_a) begin ca++; if (na == 0) begin na = n; ga = int'(vict_a); end end
      if (done_b) begin cb++; if (nb == 0) begin nb = n; gb = int'(vict_b); end end
    end
    check(ga == va, {tag_a, " victim"}, ga, va);
    check(na == la, {tag_a, " latency"}, na, la);
    check(gb == vb, {tag_b, " victim"}, gb, vb);
    check(nb == lb, {tag_b, " latency"}, nb, lb);
    check(ca == 1 && cb == 1, "R7 done pulse count", ca * 10 + cb, 11);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin age_a[i] = MAX_A; age_b[i] = MAX_B; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check(done_a == 0 && done_b == 0, "R1 done low after reset", done_a, 0);
    request("R1", "R1");

    // R4: sweep every pattern with an invalid way
    for (int p = 0; p < (1 << NW) - 1; p++) begin
      valid_i = NW'(p);
      request("R4", "R4");
    end
    valid_i = '1;
    request("R4 ages unchanged", "R4 ages unchanged");

    // R3, R6: fill all then aging search
    for (int w = 0; w < NW; w++) touch(0, 0, 1, w);
    request("R6", "R8");
    // R2: hit clears
    for (int w = 0; w < NW; w++) touch(0, 0, 1, w);
    touch(1, 0, 0, 0);
    request("R2", "R8");
    // R3: fill wins over hit on same way
    for (int w = 0; w < NW; w++) touch(1, w, 0, 0);
    touch(1, 2, 1, 2);
    request("R3", "R8");

    // near-exhaustive random sequences
    for (int it = 0; it < 400; it++) begin
      int k = $urandom_range(0, 3);
      for (int j = 0; j < k; j++)
        touch(1'($urandom_range(0, 1)), $urandom_range(0, NW - 1),
              1'($urandom_range(0, 1)), $urandom_range(0, NW - 1));
      request((age_a[0] == MAX_A || age_a[1] == MAX_A || age_a[2] == MAX_A ||
               age_a[3] == MAX_A) ? "R5" : "R6", "R8");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule